// File: doc/BRIEF.md
# Pipelined Three-Lane Best-Match Selector

This block sits behind three parallel block-matching engines. In every cycle each engine may offer one candidate score (a sum of absolute differences) and the motion vector that goes with it. The selector picks the lowest of the three scores in a registered first stage. A second stage compares that winner with a running best score and replaces the stored score and vector only when the new score is strictly lower.

A new triple can be accepted on every clock edge. A start pulse opens a new search: the stored score goes to its all-ones maximum, the stored vector goes to zero, and any triple still inside the pipeline is dropped. The producer marks the final triple of a search with a last flag. That flag moves through the pipeline with the data, and a done output rises once the final triple has been folded into the running best. At that point the best-vector output holds the vector of the lowest score seen in the search.

Top module: `best_match_cmp`

## Requirements
- R1: While reset is asserted and after it is released, the best score output is all ones (16383 at the default 14-bit width), the best vector output is zero, and done is low.
- R2: A start pulse sets the best score to all ones, the best vector to zero and done to low. Any triple presented in the same cycle as start, or accepted in the cycle before it, has no effect on the outputs.
- R3: Lane i carries its score in bits [i*SAD_W +: SAD_W] of the score bus and its vector in bits [i*MV_W +: MV_W] of the vector bus. Of the three lanes, the lane with the lowest score is the candidate.
- R4: When two or more lanes in a triple share the lowest score, the lane with the lower index is the candidate.
- R5: The stored best score and vector change only when the candidate score is strictly below the stored score. On a tie the earlier candidate is kept, including a candidate score equal to the all-ones starting value.
- R6: A triple sampled with valid high on a rising edge is reflected in the best outputs right after the next rising edge, and one triple can be accepted on every edge.
- R7: A triple presented with valid low has no effect on the outputs.
- R8: Done goes high on the same edge on which the triple carrying the last flag updates the best outputs. It is low one cycle before that edge, and it stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Opens a new search; clears the running best and the pipeline |
| in_valid | input | 1 | The triple on the input buses is valid this cycle |
| in_last | input | 1 | Marks the final triple of the search |
| sad_in | input | 3*SAD_W (42) | Three lane scores, lane 0 in the low bits |
| mv_in | input | 3*MV_W (48) | Three lane vectors, lane 0 in the low bits |
| best_sad | output | SAD_W (14) | Lowest score seen since start |
| best_mv | output | MV_W (16) | Vector of that score |
| done | output | 1 | The last triple has been folded in |

## Verification
The assertions assume that start and valid are low while reset is held. They also assume that a start pulse is not followed in the next cycle by a triple the checker expects to be merged. The assertions rely only on what the port timing guarantees. The best score never rises except through start, it stays put when no valid triple was accepted one cycle earlier, and done can only rise two edges after a last-flagged triple. The stimulus keeps valid low during reset. It applies start only before a search or to deliberately discard a triple in flight, and it checks each expected value at the cycle fixed by the two-stage latency.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int unsigned DEF_SAD_W = 14;
  localparam int unsigned DEF_MV_W  = 16;
  localparam int unsigned DEF_LANES = 3;
endpackage

// File: rtl/bmc_lane_min.sv
module bmc_lane_min #(
  parameter int unsigned SAD_W = bmc_pkg::DEF_SAD_W,
  parameter int unsigned MV_W  = bmc_pkg::DEF_MV_W,
  parameter int unsigned LANES = bmc_pkg::DEF_LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [LANES*SAD_W-1:0] sad_in,
  input  logic [LANES*MV_W-1:0]  mv_in,
  output logic                   s1_valid,
  output logic                   s1_last,
  output logic [SAD_W-1:0]       s1_sad,
  output logic [MV_W-1:0]        s1_mv
);
  logic [SAD_W-1:0] lane_sad [LANES];
  logic [MV_W-1:0]  lane_mv  [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_sad[g] = sad_in[g*SAD_W +: SAD_W];
      assign lane_mv[g]  = mv_in[g*MV_W +: MV_W];
    end
  endgenerate

  logic [SAD_W-1:0] win_sad;
  logic [MV_W-1:0]  win_mv;

  // Strict compare: lower lane index wins on ties.
  always_comb begin
    win_sad = lane_sad[0];
    win_mv  = lane_mv[0];
    for (int j = 1; j < LANES; j++) begin
      if (lane_sad[j] < win_sad) begin
        win_sad = lane_sad[j];
        win_mv  = lane_mv[j];
      end
    end
  end

  logic take;
  logic valid_d, last_d;
  assign take    = in_valid & ~flush;
  assign valid_d = take;
  assign last_d  = take & in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= valid_d;
      s1_last  <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sad <= '0;
      s1_mv  <= '0;
    end else if (take) begin
      s1_sad <= win_sad;
      s1_mv  <= win_mv;
    end
  end
endmodule

// File: rtl/bmc_best_track.sv
module bmc_best_track #(
  parameter int unsigned SAD_W = bmc_pkg::DEF_SAD_W,
  parameter int unsigned MV_W  = bmc_pkg::DEF_MV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             s1_valid,
  input  logic             s1_last,
  input  logic [SAD_W-1:0] s1_sad,
  input  logic [MV_W-1:0]  s1_mv,
  output logic [SAD_W-1:0] best_sad,
  output logic [MV_W-1:0]  best_mv,
  output logic             done
);
  localparam logic [SAD_W-1:0] SAD_MAX = {SAD_W{1'b1}};

  logic [SAD_W-1:0] sad_d;
  logic [MV_W-1:0]  mv_d;
  logic             done_d;
  logic             better;

  assign better = s1_valid & (s1_sad < best_sad);

  always_comb begin
    sad_d  = best_sad;
    mv_d   = best_mv;
    done_d = done;
    if (start) begin
      sad_d  = SAD_MAX;
      mv_d   = '0;
      done_d = 1'b0;
    end else begin
      if (better) begin
        sad_d = s1_sad;
        mv_d  = s1_mv;
      end
      if (s1_valid && s1_last) begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_sad <= SAD_MAX;
      best_mv  <= '0;
      done     <= 1'b0;
    end else begin
      best_sad <= sad_d;
      best_mv  <= mv_d;
      done     <= done_d;
    end
  end
endmodule

// File: rtl/best_match_cmp.sv
module best_match_cmp #(
  parameter int unsigned SAD_W = bmc_pkg::DEF_SAD_W,
  parameter int unsigned MV_W  = bmc_pkg::DEF_MV_W,
  parameter int unsigned LANES = bmc_pkg::DEF_LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  input  logic                   in_last,
  input  logic [LANES*SAD_W-1:0] sad_in,
  input  logic [LANES*MV_W-1:0]  mv_in,
  output logic [SAD_W-1:0]       best_sad,
  output logic [MV_W-1:0]        best_mv,
  output logic                   done
);
  logic             s1_valid;
  logic             s1_last;
  logic [SAD_W-1:0] s1_sad;
  logic [MV_W-1:0]  s1_mv;

  bmc_lane_min #(.SAD_W(SAD_W), .MV_W(MV_W), .LANES(LANES)) u_lane_min (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (start),
    .in_valid (in_valid),
    .in_last  (in_last),
    .sad_in   (sad_in),
    .mv_in    (mv_in),
    .s1_valid (s1_valid),
    .s1_last  (s1_last),
    .s1_sad   (s1_sad),
    .s1_mv    (s1_mv)
  );

  bmc_best_track #(.SAD_W(SAD_W), .MV_W(MV_W)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .s1_valid (s1_valid),
    .s1_last  (s1_last),
    .s1_sad   (s1_sad),
    .s1_mv    (s1_mv),
    .best_sad (best_sad),
    .best_mv  (best_mv),
    .done     (done)
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int unsigned SAD_W = bmc_pkg::DEF_SAD_W,
  parameter int unsigned MV_W  = bmc_pkg::DEF_MV_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             in_last,
  input logic [SAD_W-1:0] best_sad,
  input logic [MV_W-1:0]  best_mv,
  input logic             done
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (best_sad == {SAD_W{1'b1}}) && (best_mv == '0) && !done);

  // R5
  best_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> best_sad <= $past(best_sad));

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !$past(in_valid)) |=> $stable(best_sad) && $stable(best_mv));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid && in_last && !start, 2));
endmodule

bind best_match_cmp bmc_checker #(.SAD_W(SAD_W), .MV_W(MV_W)) u_bmc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_valid (in_valid),
  .in_last  (in_last),
  .best_sad (best_sad),
  .best_mv  (best_mv),
  .done     (done)
);

// File: tb/best_match_cmp_bench.sv
module best_match_cmp_bench;
  localparam int SAD_W    = 14;
  localparam int MV_W     = 16;
  localparam int CLK_T    = 10;
  localparam int N        = 9;
  localparam int WATCHDOG = 5000;
  localparam logic [SAD_W-1:0] MAXV = {SAD_W{1'b1}};

  // Rows: {lane2, lane1, lane0} scores, valid flag. Last flag on the final row.
  // Row 1 ties the stored best (R5), row 2 has a lane tie (R4),
  // row 3 is invalid (R7), row 6 is all maximum (R5).
  localparam logic [3*SAD_W-1:0] ROW_SAD [N] = '{
    {14'd400,   14'd300,   14'd500},
    {14'd300,   14'd300,   14'd300},
    {14'd260,   14'd250,   14'd250},
    {14'd900,   14'd900,   14'd100},
    {14'd249,   14'd800,   14'd900},
    {14'd500,   14'd500,   14'd249},
    {14'd16383, 14'd16383, 14'd16383},
    {14'd0,     14'd5,     14'd0},
    {14'd1,     14'd2,     14'd3}
  };
  localparam logic ROW_VALID [N] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  logic clk, rst_n, start, in_valid, in_last;
  logic [3*SAD_W-1:0] sad_in;
  logic [3*MV_W-1:0]  mv_in;
  logic [SAD_W-1:0]   best_sad;
  logic [MV_W-1:0]    best_mv;
  logic               done;

  int tests, fails, cycles;
  logic [SAD_W-1:0] exp_sad [N];
  logic [MV_W-1:0]  exp_mv  [N];

  best_match_cmp u_best_match_cmp (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_last(in_last), .sad_in(sad_in), .mv_in(mv_in),
    .best_sad(best_sad), .best_mv(best_mv), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  function automatic logic [MV_W-1:0] vec_of(int row, int lane);
    return MV_W'(row * 4 + lane + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        summary();
      end
    end
  end

  task automatic idle();
    start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    sad_in = '0; mv_in = '0;
  endtask

  initial begin
    logic [SAD_W-1:0] m_sad;
    logic [MV_W-1:0]  m_mv;
    tests = 0; fails = 0;
    // Reference model: lane minimum with low index first, then strict update.
    m_sad = MAXV; m_mv = '0;
    for (int i = 0; i < N; i++) begin
      if (ROW_VALID[i]) begin
        logic [SAD_W-1:0] c_sad;
        logic [MV_W-1:0]  c_mv;
        c_sad = ROW_SAD[i][0 +: SAD_W]; c_mv = vec_of(i, 0);
        for (int j = 1; j < 3; j++) begin
          if (ROW_SAD[i][j*SAD_W +: SAD_W] < c_sad) begin
            c_sad = ROW_SAD[i][j*SAD_W +: SAD_W]; c_mv = vec_of(i, j);
          end
        end
        if (c_sad < m_sad) begin m_sad = c_sad; m_mv = c_mv; end
      end
      exp_sad[i] = m_sad; exp_mv[i] = m_mv;
    end

    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 best_sad", 32'(best_sad), 32'(MAXV));
    check("R1 best_mv", 32'(best_mv), 0);
    check("R1 done", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // Table walk: row i driven at step i, checked at step i+2 (R3, R6).
    for (int i = 0; i < N + 2; i++) begin
      if (i >= 2) begin
        check($sformatf("R3 R6 sad row %0d", i - 2), 32'(best_sad), 32'(exp_sad[i-2]));
        check($sformatf("R3 R6 mv row %0d", i - 2), 32'(best_mv), 32'(exp_mv[i-2]));
      end
      if (i == N) check("R8 done early", 32'(done), 0);
      if (i < N) begin
        in_valid = ROW_VALID[i];
        in_last  = (i == N - 1);
        sad_in   = ROW_SAD[i];
        mv_in    = {vec_of(i, 2), vec_of(i, 1), vec_of(i, 0)};
      end else begin
        idle();
      end
      @(negedge clk);
    end
    check("R8 done high", 32'(done), 1);
    repeat (3) @(negedge clk);
    check("R8 done held", 32'(done), 1);
    check("R8 final mv", 32'(best_mv), 32'(vec_of(7, 0)));

    // R2: a triple in the same cycle as start is dropped.
    start = 1'b1; in_valid = 1'b1; sad_in = {14'd7, 14'd7, 14'd7}; mv_in = {16'd9, 16'd9, 16'd9};
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check("R2 same-cycle sad", 32'(best_sad), 32'(MAXV));
    check("R2 same-cycle done", 32'(done), 0);

    // R2: a triple accepted just before start is discarded in flight.
    in_valid = 1'b1; sad_in = {14'd4, 14'd4, 14'd4}; mv_in = {16'd3, 16'd3, 16'd3};
    @(negedge clk);
    idle(); start = 1'b1;
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check("R2 inflight sad", 32'(best_sad), 32'(MAXV));
    check("R2 inflight mv", 32'(best_mv), 0);

    // R5: a candidate equal to the all-ones starting value does not replace it.
    in_valid = 1'b1; in_last = 1'b1; sad_in = {MAXV, MAXV, MAXV}; mv_in = {16'd5, 16'd5, 16'd5};
    @(negedge clk);
    idle();
    @(negedge clk);
    check("R5 max tie mv", 32'(best_mv), 0);
    check("R8 done after max", 32'(done), 1);

    summary();
  end
endmodule